// File: doc/BRIEF.md
# Outbound Window Address Translator

This block converts addresses from an on-chip memory-mapped bus into addresses of a remote space that is either 32 or 64 bits wide. A small, fixed set of windows is configured through elaboration parameters. Each window is described by a lowest address, a highest address, a wide-space flag and a translation value. For every valid request the block finds the window that holds the address. It keeps the offset bits that lie inside that window's span and fills every bit above the span from the window's translation value.

The result appears one clock after the request. It consists of the translated address, a flag that marks a 64-bit result, the number of the window that matched, and a hit or miss indication. Each window's span must be a power of two, and its lowest address must be aligned to that span. A window that breaks this rule stops elaboration.

Top module: `outbound_xlate`

## Requirements
- R1: A request address hits window w when it is at least that window's lowest address and at most its highest address, with both limits included.
- R2: On a hit, bits of the output address inside the window span (the bits set in lowest XOR highest) equal the request address. Bits above the span equal the translation value. Translation-value bits inside the span have no effect.
- R3: For a window whose wide flag is 0, the output bits 63..32 are zero and o_is64 is 0. For a window whose wide flag is 1, o_is64 is 1 and bits 63..32 come from the translation value.
- R4: When several windows hold the address, the lowest-numbered one is reported on o_win and used for the translation.
- R5: When no window holds a valid request, o_miss is 1 and o_hit is 0. In that case o_addr, o_is64 and o_win are all zero.
- R6: o_valid is high in exactly the cycle after a cycle with i_valid high, and the result belongs to that request. Back-to-back requests give back-to-back results.
- R7: In a cycle after i_valid was low, o_valid, o_hit and o_miss are low and o_addr, o_is64 and o_win keep their previous values.
- R8: While rst is high, every output is driven to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| i_valid | input | 1 | Request strobe |
| i_addr | input | 32 | Request address |
| o_valid | output | 1 | Result strobe, one cycle after i_valid |
| o_addr | output | 64 | Translated remote address |
| o_is64 | output | 1 | Result lies in the 64-bit remote space |
| o_win | output | $clog2(NUM_WIN) | Number of the matching window |
| o_hit | output | 1 | A window matched |
| o_miss | output | 1 | No window matched |

## Verification
The bench builds the block with NUM_WIN set to 5. It keeps four windows of 64 KiB, 8 KiB, 32 MiB and 128 bytes, and adds a fifth 16 MiB window that encloses the 64 KiB one. The enclosing window makes lowest-number priority observable. The translation values carry nonzero bits inside each span, and one narrow window carries nonzero upper bits, so discarded bits would show up at the output. Window limits at 0x00000000 and 0xFFFFFFFF, together with addresses one below or one above each window, exercise the inclusive edges and misses.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

    localparam int REQ_W    = 32;
    localparam int REMOTE_W = 64;

    typedef logic [REQ_W-1:0]    req_addr_t;
    typedef logic [REMOTE_W-1:0] rem_addr_t;

    // Result of one window lookup
    typedef struct packed {
        rem_addr_t addr;
        logic      is64;
    } win_res_t;

    // Bits that pass through unchanged from the request
    function automatic req_addr_t span_mask(req_addr_t lo, req_addr_t hi);
        return lo ^ hi;
    endfunction

    // Span is a power of two and the lowest address is aligned to it
    function automatic logic span_legal(req_addr_t lo, req_addr_t hi);
        req_addr_t m;
        m = lo ^ hi;
        return (hi >= lo) && ((m & (m + 1'b1)) == '0) && ((lo & m) == '0);
    endfunction

    // Merge request offset with translation value
    function automatic rem_addr_t merge_addr(req_addr_t req, req_addr_t m,
                                             rem_addr_t xl, logic wide);
        rem_addr_t full_m;
        rem_addr_t r;
        full_m = {{(REMOTE_W-REQ_W){1'b0}}, m};
        r = (xl & ~full_m) | ({{(REMOTE_W-REQ_W){1'b0}}, req} & full_m);
        if (!wide) r[REMOTE_W-1:REQ_W] = '0;
        return r;
    endfunction

endpackage

// File: rtl/xlate_window.sv
module xlate_window
    import xlate_pkg::*;
#(
    parameter req_addr_t LO   = '0,
    parameter req_addr_t HI   = '1,
    parameter logic      WIDE = 1'b0,
    parameter rem_addr_t XL   = '0
) (
    input  req_addr_t req,
    output logic      hit,
    output win_res_t  res
);
    localparam req_addr_t MASK = span_mask(LO, HI);

    if (!span_legal(LO, HI)) begin : g_bad_span
        $error("window span must be a power of two and aligned");
    end

    always_comb begin
        hit      = (req >= LO) && (req <= HI);
        res.addr = merge_addr(req, MASK, XL, WIDE);
        res.is64 = WIDE;
    end
endmodule

// File: rtl/xlate_pick.sv
module xlate_pick
    import xlate_pkg::*;
#(
    parameter int NUM_WIN = 4,
    localparam int IDXW   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic     [NUM_WIN-1:0] hits,
    input  win_res_t [NUM_WIN-1:0] cand,
    output logic                   any,
    output logic     [IDXW-1:0]    idx,
    output win_res_t               sel
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        sel = '0;
        // walk downward so the lowest-numbered hit is written last
        for (int w = NUM_WIN - 1; w >= 0; w--) begin
            if (hits[w]) begin
                any = 1'b1;
                idx = IDXW'(w);
                sel = cand[w];
            end
        end
    end
endmodule

// File: rtl/outbound_xlate.sv
module outbound_xlate
    import xlate_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter logic [NUM_WIN-1:0][31:0] WIN_LO =
        {32'h0000_0000, 32'hFE00_0000, 32'hABCD_E000, 32'h1234_0000},
    parameter logic [NUM_WIN-1:0][31:0] WIN_HI =
        {32'h0000_007F, 32'hFFFF_FFFF, 32'hABCD_FFFF, 32'h1234_FFFF},
    parameter logic [NUM_WIN-1:0]       WIN_WIDE = 4'b1010,
    parameter logic [NUM_WIN-1:0][63:0] WIN_XL =
        {64'h6000_0000_8765_4380, 64'h0000_0000_4000_0000,
         64'h5000_0000_FEDC_0000, 64'h0000_0000_5671_0000},
    localparam int IDXW = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            i_valid,
    input  logic [31:0]     i_addr,
    output logic            o_valid,
    output logic [63:0]     o_addr,
    output logic            o_is64,
    output logic [IDXW-1:0] o_win,
    output logic            o_hit,
    output logic            o_miss
);
    logic     [NUM_WIN-1:0] hits;
    win_res_t [NUM_WIN-1:0] cand;
    logic                   any_hit;
    logic     [IDXW-1:0]    pick_idx;
    win_res_t               pick_res;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        xlate_window #(
            .LO   (WIN_LO[w]),
            .HI   (WIN_HI[w]),
            .WIDE (WIN_WIDE[w]),
            .XL   (WIN_XL[w])
        ) u_win (
            .req (i_addr),
            .hit (hits[w]),
            .res (cand[w])
        );
    end

    xlate_pick #(.NUM_WIN(NUM_WIN)) u_pick (
        .hits (hits),
        .cand (cand),
        .any  (any_hit),
        .idx  (pick_idx),
        .sel  (pick_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            o_valid <= 1'b0;
            o_hit   <= 1'b0;
            o_miss  <= 1'b0;
            o_addr  <= '0;
            o_is64  <= 1'b0;
            o_win   <= '0;
        end else begin
            o_valid <= i_valid;
            o_hit   <= i_valid && any_hit;
            o_miss  <= i_valid && !any_hit;
            if (i_valid) begin
                o_addr <= pick_res.addr;
                o_is64 <= pick_res.is64;
                o_win  <= pick_idx;
            end
        end
    end
endmodule

// File: rtl/outbound_xlate_chk.sv
module outbound_xlate_chk #(
    parameter int NUM_WIN = 4,
    parameter logic [NUM_WIN-1:0][31:0] WIN_LO = '0,
    parameter logic [NUM_WIN-1:0][31:0] WIN_HI = '1,
    parameter logic [NUM_WIN-1:0]       WIN_WIDE = '0,
    localparam int IDXW = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input logic            clk,
    input logic            rst,
    input logic            i_valid,
    input logic [31:0]     i_addr,
    input logic            o_valid,
    input logic [63:0]     o_addr,
    input logic            o_is64,
    input logic [IDXW-1:0] o_win,
    input logic            o_hit,
    input logic            o_miss
);
    a_r6_result_follows: assert property (@(posedge clk) disable iff (rst)
        i_valid |=> o_valid);
    a_r7_no_result: assert property (@(posedge clk) disable iff (rst)
        !i_valid |=> !o_valid && !o_hit && !o_miss);
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !i_valid |=> $stable(o_addr) && $stable(o_is64) && $stable(o_win));
    a_r5_one_outcome: assert property (@(posedge clk) disable iff (rst)
        o_valid |-> $onehot({o_hit, o_miss}));
    a_r5_miss_zero: assert property (@(posedge clk) disable iff (rst)
        o_miss |-> (o_addr == '0) && !o_is64 && (o_win == '0));
    a_r3_narrow_upper: assert property (@(posedge clk) disable iff (rst)
        (o_hit && !o_is64) |-> (o_addr[63:32] == '0));

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_chk
        a_r1_in_range: assert property (@(posedge clk) disable iff (rst)
            (o_hit && o_win == IDXW'(w)) |->
            ($past(i_addr) >= WIN_LO[w]) && ($past(i_addr) <= WIN_HI[w]));
        a_r2_offset: assert property (@(posedge clk) disable iff (rst)
            (o_hit && o_win == IDXW'(w)) |->
            (((o_addr[31:0] ^ $past(i_addr)) & (WIN_LO[w] ^ WIN_HI[w])) == '0));
        a_r3_space_flag: assert property (@(posedge clk) disable iff (rst)
            (o_hit && o_win == IDXW'(w)) |-> (o_is64 == WIN_WIDE[w]));
    end
endmodule

bind outbound_xlate outbound_xlate_chk #(
    .NUM_WIN  (NUM_WIN),
    .WIN_LO   (WIN_LO),
    .WIN_HI   (WIN_HI),
    .WIN_WIDE (WIN_WIDE)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .i_valid (i_valid),
    .i_addr  (i_addr),
    .o_valid (o_valid),
    .o_addr  (o_addr),
    .o_is64  (o_is64),
    .o_win   (o_win),
    .o_hit   (o_hit),
    .o_miss  (o_miss)
);

// File: tb/sim_outbound_xlate.sv
module sim_outbound_xlate;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        i_valid = 1'b0;
    logic [31:0] i_addr = '0;
    logic        o_valid;
    logic [63:0] o_addr;
    logic        o_is64;
    logic [2:0]  o_win;
    logic        o_hit;
    logic        o_miss;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    outbound_xlate #(
        .NUM_WIN  (5),
        .WIN_LO   ({32'h1200_0000, 32'h0000_0000, 32'hFE00_0000,
                    32'hABCD_E000, 32'h1234_0000}),
        .WIN_HI   ({32'h12FF_FFFF, 32'h0000_007F, 32'hFFFF_FFFF,
                    32'hABCD_FFFF, 32'h1234_FFFF}),
        .WIN_WIDE (5'b11010),
        .WIN_XL   ({64'h0000_0001_0000_0000, 64'h6000_0000_8765_438F,
                    64'hFFFF_FFFF_40FF_FFFF, 64'h5000_0000_FEDC_0FFF,
                    64'h0000_0000_5671_BEEF})
    ) u0 (
        .clk     (clk),
        .rst     (rst),
        .i_valid (i_valid),
        .i_addr  (i_addr),
        .o_valid (o_valid),
        .o_addr  (o_addr),
        .o_is64  (o_is64),
        .o_win   (o_win),
        .o_hit   (o_hit),
        .o_miss  (o_miss)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one request at a falling edge, sample result at the next one
    task automatic expect_hit(input string req, input logic [31:0] a,
                              input logic [63:0] ea, input logic e64,
                              input logic [2:0] ew);
        i_valid = 1'b1;
        i_addr  = a;
        @(negedge clk);
        check(o_valid && o_hit && !o_miss, {req, " hit/valid"},
              {61'd0, o_valid, o_hit, o_miss}, 64'b110);
        check(o_addr == ea, {req, " addr"}, o_addr, ea);
        check(o_is64 == e64, {req, " is64"}, {63'd0, o_is64}, {63'd0, e64});
        check(o_win == ew, {req, " win"}, {61'd0, o_win}, {61'd0, ew});
    endtask

    task automatic expect_miss(input string req, input logic [31:0] a);
        i_valid = 1'b1;
        i_addr  = a;
        @(negedge clk);
        check(o_valid && o_miss && !o_hit, {req, " miss flags"},
              {61'd0, o_valid, o_hit, o_miss}, 64'b101);
        check(o_addr == '0 && !o_is64 && o_win == '0, {req, " miss zero"},
              o_addr, 64'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(!o_valid && !o_hit && !o_miss && o_addr == '0 && !o_is64
              && o_win == '0, "R8 reset", o_addr, 64'd0);
        rst = 1'b0;
    endtask

    task automatic t_windows();
        expect_hit("R2 w0", 32'h1234_0ABC, 64'h0000_0000_5671_0ABC, 1'b0, 3'd0);
        expect_hit("R2 w1", 32'hABCD_F123, 64'h5000_0000_FEDC_1123, 1'b1, 3'd1);
        expect_hit("R3 w2", 32'hFFFE_DCBA, 64'h0000_0000_41FE_DCBA, 1'b0, 3'd2);
        expect_hit("R3 w3", 32'h0000_0071, 64'h6000_0000_8765_43F1, 1'b1, 3'd3);
    endtask

    task automatic t_edges();
        expect_hit("R1 w2 top", 32'hFFFF_FFFF, 64'h0000_0000_41FF_FFFF, 1'b0, 3'd2);
        expect_hit("R1 w2 low", 32'hFE00_0000, 64'h0000_0000_4000_0000, 1'b0, 3'd2);
        expect_hit("R1 w3 zero", 32'h0000_0000, 64'h6000_0000_8765_4380, 1'b1, 3'd3);
        expect_hit("R1 w1 low", 32'hABCD_E000, 64'h5000_0000_FEDC_0000, 1'b1, 3'd1);
        expect_hit("R1 w0 top", 32'h1234_FFFF, 64'h0000_0000_5671_FFFF, 1'b0, 3'd0);
    endtask

    task automatic t_miss();
        expect_miss("R5 below w2", 32'hFDFF_FFFF);
        expect_miss("R5 above w3", 32'h0000_0080);
        expect_miss("R5 below w1", 32'hABCD_DFFF);
        expect_miss("R5 above w1", 32'hABCE_0000);
    endtask

    task automatic t_priority();
        expect_hit("R4 overlap", 32'h1234_0010, 64'h0000_0000_5671_0010, 1'b0, 3'd0);
        expect_hit("R4 outer", 32'h1235_0000, 64'h0000_0001_0035_0000, 1'b1, 3'd4);
        expect_hit("R4 outer low", 32'h1233_FFFF, 64'h0000_0001_0033_FFFF, 1'b1, 3'd4);
    endtask

    task automatic t_idle();
        expect_hit("R6 before idle", 32'hABCD_E456, 64'h5000_0000_FEDC_0456, 1'b1, 3'd1);
        i_valid = 1'b0;
        i_addr  = 32'h1234_0000;
        @(negedge clk);
        check(!o_valid && !o_hit && !o_miss, "R7 idle flags",
              {61'd0, o_valid, o_hit, o_miss}, 64'd0);
        check(o_addr == 64'h5000_0000_FEDC_0456 && o_is64 && o_win == 3'd1,
              "R7 hold", o_addr, 64'h5000_0000_FEDC_0456);
        @(negedge clk);
        check(!o_valid && o_addr == 64'h5000_0000_FEDC_0456, "R6 no spurious",
              o_addr, 64'h5000_0000_FEDC_0456);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_windows();
        t_edges();
        t_miss();
        t_priority();
        t_idle();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule